// File: doc/BRIEF.md
# Alternate-Lane Crosstalk Inversion Encoder

This block sits in a network interface just ahead of a serializer. It takes one wide flit and treats it as a set of parallel lanes. Each lane carries a short word that is later shifted out one bit per time step, least significant bit first. The block lowers the power that the coupling capacitance between adjacent wires draws.

Lanes are paired as even lane 2i with odd lane 2i+1. For each pair, the encoder walks across consecutive time steps and finds the steps where both wires toggle. It counts the steps where they move in opposite directions (rising against falling) and the steps where they move together. When the opposite-direction count is strictly larger, every bit of the odd lane is complemented for that flit. Complementing one wire of a pair turns every opposite move into a joint move, and every joint move into an opposite move. The number of toggles on the wire stays the same, so any earlier saving in self-switching is kept. One flag per odd lane travels beside the data as an extra control lane.

A combinational decoder port undoes the inversion for the receiving side. The encoder has a valid/ready handshake on its input and on its output, with one register stage between them.

Top module: `xtalk_inv_enc`

## Requirements
- R1: After reset, outValid is 0, outFlags is 0 and inReady is 1.
- R2: Even lanes reach outFlit unchanged. Lane j occupies flit bits [j*STEPS +: STEPS], and time step s is bit s of that slice.
- R3: For each pair i, flag bit i of outFlags is 1 exactly when the opposite-direction count is greater than the same-direction count. Both counts are taken between lane 2i and lane 2i+1 over steps s-1 to s, for s = 1 to STEPS-1. A tie or zero gives 0. When the flag is 1, odd lane 2i+1 is fully complemented. When it is 0, the odd lane is unchanged.
- R4: Every lane of outFlit has the same number of bit toggles between adjacent time steps as the matching lane of the accepted flit.
- R5: For every pair (2i, 2i+1), the coupling cost after encoding is never greater than before. The cost weights a step with only one wire toggling as 1, an opposite-direction step as 2, and same-direction or still steps as 0.
- R6: A flit is accepted on a clock edge where inValid and inReady are both 1. Its encoded form is on outFlit/outFlags with outValid = 1 from the next cycle.
- R7: While outValid is 1 and outReady is 0, outValid, outFlit and outFlags hold their values.
- R8: inReady is 1 whenever the output stage is empty or outReady is 1, and 0 otherwise.
- R9: decData equals decFlit with odd lane 2i+1 complemented for each set bit i of decFlags. Feeding the encoder output into the decoder returns the accepted flit exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input flit present |
| inReady | output | 1 | Encoder can accept a flit |
| inFlit | input | LANES*STEPS | Flit from the previous coding stage |
| outValid | output | 1 | Encoded flit present |
| outReady | input | 1 | Downstream accepts the encoded flit |
| outFlit | output | LANES*STEPS | Encoded flit |
| outFlags | output | LANES/2 | Inversion flag per odd lane |
| decFlit | input | LANES*STEPS | Received encoded flit |
| decFlags | input | LANES/2 | Received inversion flags |
| decData | output | LANES*STEPS | Restored flit |

## Verification
The properties assume that inValid is 0 while reset is held. This keeps the one-cycle look back at an acceptance from using a value that was driven before the first edge; the stimulus drops inValid during reset and raises it only afterwards. The hold property assumes that downstream never lowers outValid on its own. The bench drives inputs only at falling edges and changes outReady only between edges, so every acceptance and every stall is a clean single-edge event. Random flits come from a fixed seed and are mixed with directed patterns: all-opposite, all-together, an exact tie and all-zero lanes.

// File: rtl/xinv_pkg.sv
package xinv_pkg;

  typedef struct packed {
    logic load;
  } xinvStrobe_t;

  // Build a full-width mask that covers every odd lane whose flag is set.
  function automatic logic [63:0] flagsToMask(input logic [31:0] flags,
                                              input int lanes,
                                              input int steps);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < lanes / 2; i++) begin
      if (flags[i]) begin
        for (int s = 0; s < steps; s++) m[(2 * i + 1) * steps + s] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/xinv_pair_vote.sv
module xinv_pair_vote #(
  parameter int STEPS = 8
) (
  input  logic [STEPS-1:0] evenLane,
  input  logic [STEPS-1:0] oddLane,
  output logic             invert
);
  localparam int CNTW = $clog2(STEPS) + 1;

  logic [CNTW-1:0] oppCount;
  logic [CNTW-1:0] sameCount;

  always_comb begin
    oppCount  = '0;
    sameCount = '0;
    for (int s = 1; s < STEPS; s++) begin
      if ((evenLane[s] ^ evenLane[s-1]) && (oddLane[s] ^ oddLane[s-1])) begin
        if (evenLane[s] != oddLane[s]) oppCount = oppCount + CNTW'(1);
        else                           sameCount = sameCount + CNTW'(1);
      end
    end
  end

  assign invert = (oppCount > sameCount);
endmodule

// File: rtl/xinv_ctrl.sv
module xinv_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic                  outReady,
  output logic                  inReady,
  output logic                  outValid,
  output xinv_pkg::xinvStrobe_t strobe
);
  logic full;

  assign inReady     = !full || outReady;
  assign strobe.load = inValid && inReady;
  assign outValid    = full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           full <= 1'b0;
    else if (strobe.load) full <= 1'b1;
    else if (outReady)    full <= 1'b0;
  end
endmodule

// File: rtl/xinv_datapath.sv
module xinv_datapath #(
  parameter int LANES = 8,
  parameter int STEPS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  xinv_pkg::xinvStrobe_t       strobe,
  input  logic [LANES*STEPS-1:0]      inFlit,
  output logic [LANES*STEPS-1:0]      outFlit,
  output logic [LANES/2-1:0]          outFlags
);
  localparam int NPAIR = LANES / 2;
  localparam int WIDTH = LANES * STEPS;

  logic [NPAIR-1:0] voteInv;
  logic [WIDTH-1:0] codedFlit;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic [STEPS-1:0] evenBits;
    logic [STEPS-1:0] oddBits;
    assign evenBits = inFlit[(2*i)*STEPS +: STEPS];
    assign oddBits  = inFlit[(2*i+1)*STEPS +: STEPS];

    xinv_pair_vote #(.STEPS(STEPS)) u_vote (
      .evenLane(evenBits),
      .oddLane (oddBits),
      .invert  (voteInv[i])
    );

    assign codedFlit[(2*i)*STEPS +: STEPS]   = evenBits;
    assign codedFlit[(2*i+1)*STEPS +: STEPS] = oddBits ^ {STEPS{voteInv[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outFlit  <= '0;
      outFlags <= '0;
    end else if (strobe.load) begin
      outFlit  <= codedFlit;
      outFlags <= voteInv;
    end
  end
endmodule

// File: rtl/xinv_decoder.sv
module xinv_decoder #(
  parameter int LANES = 8,
  parameter int STEPS = 8
) (
  input  logic [LANES*STEPS-1:0] decFlit,
  input  logic [LANES/2-1:0]     decFlags,
  output logic [LANES*STEPS-1:0] decData
);
  for (genvar i = 0; i < LANES / 2; i++) begin : g_lane
    assign decData[(2*i)*STEPS +: STEPS]   = decFlit[(2*i)*STEPS +: STEPS];
    assign decData[(2*i+1)*STEPS +: STEPS] = decFlit[(2*i+1)*STEPS +: STEPS]
                                             ^ {STEPS{decFlags[i]}};
  end
endmodule

// File: rtl/xtalk_inv_enc.sv
module xtalk_inv_enc #(
  parameter int LANES = 8,
  parameter int STEPS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [LANES*STEPS-1:0]   inFlit,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [LANES*STEPS-1:0]   outFlit,
  output logic [LANES/2-1:0]       outFlags,
  input  logic [LANES*STEPS-1:0]   decFlit,
  input  logic [LANES/2-1:0]       decFlags,
  output logic [LANES*STEPS-1:0]   decData
);
  xinv_pkg::xinvStrobe_t strobe;

  xinv_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  xinv_datapath #(.LANES(LANES), .STEPS(STEPS)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .inFlit  (inFlit),
    .outFlit (outFlit),
    .outFlags(outFlags)
  );

  xinv_decoder #(.LANES(LANES), .STEPS(STEPS)) u_dec (
    .decFlit (decFlit),
    .decFlags(decFlags),
    .decData (decData)
  );
endmodule

// File: rtl/xinv_checker.sv
module xinv_checker #(
  parameter int LANES = 8,
  parameter int STEPS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   inValid,
  input logic                   inReady,
  input logic [LANES*STEPS-1:0] inFlit,
  input logic                   outValid,
  input logic                   outReady,
  input logic [LANES*STEPS-1:0] outFlit,
  input logic [LANES/2-1:0]     outFlags,
  input logic [LANES*STEPS-1:0] decFlit,
  input logic [LANES/2-1:0]     decFlags,
  input logic [LANES*STEPS-1:0] decData
);
  localparam int W = LANES * STEPS;

  function automatic int laneToggles(input logic [W-1:0] f, input int lane);
    int n;
    n = 0;
    for (int s = 1; s < STEPS; s++)
      if (f[lane*STEPS+s] != f[lane*STEPS+s-1]) n++;
    return n;
  endfunction

  function automatic bit togglesMatch(input logic [W-1:0] a, input logic [W-1:0] b);
    bit ok;
    ok = 1'b1;
    for (int j = 0; j < LANES; j++)
      if (laneToggles(a, j) != laneToggles(b, j)) ok = 1'b0;
    return ok;
  endfunction

  function automatic int pairCost(input logic [W-1:0] f);
    int c;
    logic ta, tb;
    c = 0;
    for (int i = 0; i < LANES / 2; i++) begin
      for (int s = 1; s < STEPS; s++) begin
        ta = f[(2*i)*STEPS+s] ^ f[(2*i)*STEPS+s-1];
        tb = f[(2*i+1)*STEPS+s] ^ f[(2*i+1)*STEPS+s-1];
        if (ta ^ tb) c += 1;
        else if (ta && tb && (f[(2*i)*STEPS+s] != f[(2*i+1)*STEPS+s])) c += 2;
      end
    end
    return c;
  endfunction

  // R1 / R8: an empty output stage never refuses input
  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> inReady);

  a_r6_accept_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid);

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outFlit) && $stable(outFlags)));

  a_r3_only_flagged_odd_change: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(inValid && inReady)) |->
      ((outFlit ^ $past(inFlit)) ==
       W'(xinv_pkg::flagsToMask(32'(outFlags), LANES, STEPS))));

  a_r4_toggles_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(inValid && inReady)) |-> togglesMatch(outFlit, $past(inFlit)));

  a_r5_cost_not_worse: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(inValid && inReady)) |-> (pairCost(outFlit) <= pairCost($past(inFlit))));

  a_r9_clear_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (decFlags == '0) |-> (decData == decFlit));
endmodule

bind xtalk_inv_enc xinv_checker #(.LANES(LANES), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .inFlit(inFlit),
  .outValid(outValid), .outReady(outReady), .outFlit(outFlit), .outFlags(outFlags),
  .decFlit(decFlit), .decFlags(decFlags), .decData(decData)
);

// File: tb/sim_xtalk_inv_enc.sv
module sim_xtalk_inv_enc;
  localparam int LANES = 8;
  localparam int STEPS = 8;
  localparam int W     = LANES * STEPS;
  localparam int NP    = LANES / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [W-1:0]  inFlit = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [W-1:0]  outFlit;
  logic [NP-1:0] outFlags;
  logic [W-1:0]  decFlit = '0;
  logic [NP-1:0] decFlags = '0;
  logic [W-1:0]  decData;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  xtalk_inv_enc #(.LANES(LANES), .STEPS(STEPS)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady), .inFlit(inFlit),
    .outValid(outValid), .outReady(outReady), .outFlit(outFlit), .outFlags(outFlags),
    .decFlit(decFlit), .decFlags(decFlags), .decData(decData)
  );

  function automatic logic [STEPS-1:0] laneOf(input logic [W-1:0] f, input int j);
    return f[j*STEPS +: STEPS];
  endfunction

  // Flag per pair: opposite-direction steps strictly outnumber joint steps
  function automatic logic [NP-1:0] modelFlags(input logic [W-1:0] f);
    logic [NP-1:0] r;
    logic [STEPS-1:0] a, b;
    int opp, same;
    r = '0;
    for (int i = 0; i < NP; i++) begin
      a = laneOf(f, 2*i);
      b = laneOf(f, 2*i+1);
      opp = 0; same = 0;
      for (int s = 1; s < STEPS; s++) begin
        if (a[s] != a[s-1] && b[s] != b[s-1]) begin
          if (a[s-1] == 1'b0 && b[s-1] == 1'b1) opp++;
          else if (a[s-1] == 1'b1 && b[s-1] == 1'b0) opp++;
          else same++;
        end
      end
      r[i] = (opp > same);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] modelEncode(input logic [W-1:0] f);
    logic [W-1:0] r;
    logic [NP-1:0] fl;
    fl = modelFlags(f);
    r = f;
    for (int i = 0; i < NP; i++)
      if (fl[i]) r[(2*i+1)*STEPS +: STEPS] = ~f[(2*i+1)*STEPS +: STEPS];
    return r;
  endfunction

  function automatic logic [W-1:0] evenMask();
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < NP; i++) m[(2*i)*STEPS +: STEPS] = '1;
    return m;
  endfunction

  function automatic int toggleCount(input logic [STEPS-1:0] v);
    int n;
    n = 0;
    for (int s = 1; s < STEPS; s++) if (v[s] != v[s-1]) n++;
    return n;
  endfunction

  function automatic int costOf(input logic [W-1:0] f);
    int c;
    logic [STEPS-1:0] a, b;
    c = 0;
    for (int i = 0; i < NP; i++) begin
      a = laneOf(f, 2*i);
      b = laneOf(f, 2*i+1);
      for (int s = 1; s < STEPS; s++) begin
        if ((a[s] != a[s-1]) != (b[s] != b[s-1])) c += 1;
        else if (a[s] != a[s-1] && a[s-1] != b[s-1]) c += 2;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic verifyOut(input logic [W-1:0] f);
    logic [W-1:0] enc;
    int tIn, tOut;
    enc = modelEncode(f);
    check(outValid == 1'b1, "R6 outValid after accept", W'(outValid), W'(1));
    check(outFlags == modelFlags(f), "R3 flags", W'(outFlags), W'(modelFlags(f)));
    check(outFlit == enc, "R3 encoded flit", outFlit, enc);
    check((outFlit & evenMask()) == (f & evenMask()), "R2 even lanes",
          outFlit & evenMask(), f & evenMask());
    tIn = 0; tOut = 0;
    for (int j = 0; j < LANES; j++) begin
      if (toggleCount(laneOf(outFlit, j)) != toggleCount(laneOf(f, j))) tOut++;
    end
    check(tOut == 0, "R4 toggle counts", W'(tOut), W'(tIn));
    check(costOf(outFlit) <= costOf(f), "R5 pair cost", W'(costOf(outFlit)), W'(costOf(f)));
    decFlit  = outFlit;
    decFlags = outFlags;
    #1;
    check(decData == f, "R9 round trip", decData, f);
  endtask

  task automatic sendOne(input logic [W-1:0] f);
    @(negedge clk);
    inFlit   = f;
    inValid  = 1'b1;
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    verifyOut(f);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [W-1:0] fa, fb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid in reset", W'(outValid), W'(0));
    check(outFlags == '0, "R1 outFlags in reset", W'(outFlags), W'(0));
    check(inReady == 1'b1, "R1 inReady in reset", W'(inReady), W'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", W'(outValid), W'(0));

    // Directed: lanes 0/1 move opposite on every step -> flag 0 set (R3)
    sendOne({48'h0, 8'hAA, 8'h55});
    check(outFlags == 4'b0001, "R3 opposite pattern flag", W'(outFlags), W'(4'b0001));
    // Directed: lanes move together -> no inversion (R3)
    sendOne({48'h0, 8'h55, 8'h55});
    check(outFlags == 4'b0000, "R3 joint pattern flag", W'(outFlags), W'(0));
    // Directed: one opposite step and one joint step, a tie -> no inversion (R3)
    sendOne({48'h0, 8'h06, 8'h05});
    check(outFlags == 4'b0000, "R3 tie flag", W'(outFlags), W'(0));
    // Directed: every pair opposite -> all flags (R3)
    sendOne({4{8'hAA, 8'h55}});
    check(outFlags == 4'b1111, "R3 all pairs flag", W'(outFlags), W'(4'hF));
    // Directed: all zero and all one flits (R2, R3)
    sendOne('0);
    sendOne('1);

    // Backpressure: R7 and R8
    @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R6 drained", W'(outValid), W'(0));
    fa = {8'h33, 8'hCC, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h01, 8'h02};
    fb = {8'h12, 8'h34, 8'hAA, 8'h55, 8'hC3, 8'h3C, 8'h99, 8'h66};
    outReady = 1'b0;
    inFlit   = fa;
    inValid  = 1'b1;
    @(negedge clk);
    check(outFlit == modelEncode(fa), "R6 first held flit", outFlit, modelEncode(fa));
    inFlit = fb;
    for (int k = 0; k < 3; k++) begin
      check(inReady == 1'b0, "R8 ready low while full and stalled", W'(inReady), W'(0));
      check(outValid == 1'b1, "R7 valid held", W'(outValid), W'(1));
      check(outFlit == modelEncode(fa), "R7 flit held", outFlit, modelEncode(fa));
      check(outFlags == modelFlags(fa), "R7 flags held", W'(outFlags), W'(modelFlags(fa)));
      @(negedge clk);
    end
    outReady = 1'b1;
    #1;
    check(inReady == 1'b1, "R8 ready when downstream ready", W'(inReady), W'(1));
    @(negedge clk);
    inValid = 1'b0;
    verifyOut(fb);

    // Random flits from a fixed seed
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      fa = {$urandom, $urandom};
      sendOne(fa);
    end

    finishRun();
  end
endmodule